// File: doc/BRIEF.md
# Random Output Word Sequencer

This block sits between a memory-mapped register port and a stand-in random generator. Software starts work by writing the control register. Depending on a mode bit, the write either reseeds the generator or runs a generate. A generate makes a batch of 32-bit words available. Software then drains the words by reading a fixed output offset. A status field shows how many words remain, but it saturates at a small ceiling. In automatic mode the block refills by itself once the remaining count falls low enough.

The block also has a hard reset register, a soft reset bit in the control register and a budget of generates between reseeds. A generate that finds the budget exhausted reseeds first. The hardware version is set by a parameter, and it changes which control bits software may set and whether the auxiliary control registers can be written. The word source is a 32-bit xorshift stand-in with no cryptographic strength. All accesses are whole 32-bit words. A read returns its data in the cycle after the request.

Top module: `rng_word_seq`

## Requirements
- R1: After `rst`, the reset register (offset 0xD0, bit 0) reads 1, status (0x04) reads 0, auxiliary control 2 (0x0C) reads 0x210C, auxiliary control 3 (0x10) reads 0x26F09 and `done` is 0.
- R2: A control (0x08) write with bit 5 (start) and bit 7 (generate mode) set, outside reset and with bit 0 clear, makes 8 words available, sets status bits 11:9 (queue count) to 4, sets status bit 0 and raises `done`.
- R3: A control write with start set and bit 7 clear reseeds: the generator state is set to `SEED`, the budget is set to 2^`BUDGET_LOG2`, `done` is set and the available-word count is left unchanged.
- R4: A read of 0xC0 with words available returns the next xorshift word (x^=x<<13; x^=x>>17; x^=x<<5, applied to the state) and decrements the count. The queue count field stays at 4 until the count drops below 4, and then it equals the count.
- R5: A read of 0xC0 with no words available returns 0x00000BAD, pulses `sw_err` alongside `rvalid`, and leaves the count and the state unchanged.
- R6: When control bit 9 (single generation) is clear and the stored start bit is set, a word read that leaves 3 or fewer words runs another generate, so the count returns to 8. With bit 9 set, no refill happens.
- R7: The block is in reset while the reset register bit or control bit 0 is set. A word read in reset returns 0xBAD with `sw_err`. A control write made while the reset register is 1 is stored but starts nothing.
- R8: A control write with bit 0 set, made while the reset register is 0, clears the word count, the whole status register and `done`.
- R9: Writing 1 to the reset register while it holds 0 restores every register to its reset value, empties the word count and returns the generator state and budget to their reset values (state `SEED`, budget 0).
- R10: With `HW_VERSION` below 0x0200, control bits 9 and 10 are forced to 0 on write, and writes to 0x0C, 0x10 and 0x14 are ignored.
- R11: With `HW_VERSION` of 0x0200 or above, control bits 1 and 4 are forced to 0 on write, and 0x0C, 0x10 and 0x14 are writable and read back.
- R12: A generate, explicit or automatic, that finds the budget at 0 first reseeds, so the word sequence restarts from `SEED`. Every generate uses up one unit of budget.
- R13: Every read request produces `rvalid` with its data in the following cycle. A word read returns the word before any refill on the same access takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset of the 32-bit register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read response valid, one cycle after a read request |
| sw_err | output | 1 | Word read refused (empty or in reset), with `rvalid` |
| done | output | 1 | Completion flag of the last explicit generate or reseed |

## Verification
The bench builds two copies of the block. The main copy uses `HW_VERSION` 0x0200 and `BUDGET_LOG2` set to 2. With a budget of four generates, both the explicit and the automatic budget-exhaustion reseed occur within a few dozen reads, which a 2^48 budget never reaches. A second copy uses `HW_VERSION` 0x0100, which brings the legacy write masking and the ignored auxiliary registers within reach. Both copies share `SEED`, so the bench can predict every drained word from the xorshift recurrence.

// File: rtl/rng_seq_pkg.sv
package rng_seq_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int QCNT_W = 3;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_AUX2   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_AUX3   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_AUX4   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WORD   = 8'hC0;
    localparam logic [ADDR_W-1:0] OFS_RESET  = 8'hD0;

    // control bit positions
    localparam int CB_SOFT_RST = 0;
    localparam int CB_OLD_A    = 1;
    localparam int CB_OLD_B    = 4;
    localparam int CB_START    = 5;
    localparam int CB_GEN      = 7;
    localparam int CB_SINGLE   = 9;
    localparam int CB_NOPERS   = 10;

    // status bit positions
    localparam int SB_DONE = 0;
    localparam int SB_QLO  = 9;

    localparam logic [DATA_W-1:0] AUX2_INIT = 32'h0000_210C;
    localparam logic [DATA_W-1:0] AUX3_INIT = 32'h0002_6F09;
    localparam logic [DATA_W-1:0] BAD_WORD  = 32'h0000_0BAD;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_RESEED,
        ACT_GEN,
        ACT_SOFT
    } ctrl_act_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // one step of the stand-in word source
    function automatic logic [DATA_W-1:0] xs32_step(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // what an accepted control write asks for
    function automatic ctrl_act_e ctrl_action(input logic [DATA_W-1:0] v,
                                              input logic hold);
        if (hold)
            return ACT_IDLE;
        if (v[CB_SOFT_RST])
            return ACT_SOFT;
        if (!v[CB_START])
            return ACT_IDLE;
        return v[CB_GEN] ? ACT_GEN : ACT_RESEED;
    endfunction

endpackage

// File: rtl/rng_ctl_regs.sv
module rng_ctl_regs
    import rng_seq_pkg::*;
#(
    parameter logic [15:0] HW_VERSION = 16'h0200
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          bus,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] aux2_q,
    output logic [DATA_W-1:0] aux3_q,
    output logic [DATA_W-1:0] aux4_q,
    output logic              reset_q,
    output logic              restore,
    output logic              ctrl_wr,
    output logic [DATA_W-1:0] ctrl_wval
);

    localparam logic [DATA_W-1:0] ONE = 32'd1;

    logic [DATA_W-1:0] keep_mask;
    logic              aux_wen;
    logic              wr;

    generate
        if (HW_VERSION < 16'h0200) begin : g_legacy
            assign keep_mask = ~((ONE << CB_SINGLE) | (ONE << CB_NOPERS));
            assign aux_wen   = 1'b0;
        end else begin : g_current
            assign keep_mask = ~((ONE << CB_OLD_A) | (ONE << CB_OLD_B));
            assign aux_wen   = 1'b1;
        end
    endgenerate

    assign wr        = bus.req & bus.we;
    assign ctrl_wr   = wr & (bus.addr == OFS_CTRL);
    assign ctrl_wval = bus.wdata & keep_mask;
    assign restore   = wr & (bus.addr == OFS_RESET) & bus.wdata[0] & ~reset_q;

    always_ff @(posedge clk) begin
        if (rst || restore) begin
            ctrl_q  <= '0;
            aux2_q  <= AUX2_INIT;
            aux3_q  <= AUX3_INIT;
            aux4_q  <= '0;
            reset_q <= 1'b1;
        end else if (wr) begin
            case (bus.addr)
                OFS_CTRL:  ctrl_q <= ctrl_wval;
                OFS_AUX2:  if (aux_wen) aux2_q <= bus.wdata;
                OFS_AUX3:  if (aux_wen) aux3_q <= bus.wdata;
                OFS_AUX4:  if (aux_wen) aux4_q <= bus.wdata;
                OFS_RESET: reset_q <= bus.wdata[0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/rng_word_src.sv
module rng_word_src
    import rng_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED        = 32'h1234_5678,
    parameter int                BUDGET_LOG2 = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restore,
    input  logic              reseed,
    input  logic              gen,
    input  logic              advance,
    output logic [DATA_W-1:0] word_o
);

    localparam int BW = BUDGET_LOG2 + 1;
    localparam logic [BW-1:0] BUDGET_FULL = {1'b1, {BUDGET_LOG2{1'b0}}};

    logic [DATA_W-1:0] state_q;
    logic [BW-1:0]     budget_q;
    logic              exhausted;

    assign word_o    = xs32_step(state_q);
    assign exhausted = (budget_q == '0);

    always_ff @(posedge clk) begin
        if (rst || restore) begin
            state_q  <= SEED;
            budget_q <= '0;
        end else if (reseed) begin
            state_q  <= SEED;
            budget_q <= BUDGET_FULL;
        end else if (gen && exhausted) begin
            // forced reseed, then this generate uses one unit
            state_q  <= SEED;
            budget_q <= BUDGET_FULL - 1'b1;
        end else begin
            if (advance)
                state_q <= word_o;
            if (gen)
                budget_q <= budget_q - 1'b1;
        end
    end

endmodule

// File: rtl/rng_avail_ctr.sv
module rng_avail_ctr
    import rng_seq_pkg::*;
#(
    parameter int WORDS_PER_GEN = 8,
    parameter int QCNT_MAX      = 4,
    localparam int CW           = $clog2(WORDS_PER_GEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic              consume,
    output logic [CW-1:0]     count_o,
    output logic [CW-1:0]     left_o,
    output logic [QCNT_W-1:0] qcnt_o,
    output logic              empty_o
);

    localparam logic [CW-1:0]     FULL = CW'(WORDS_PER_GEN);
    localparam logic [CW-1:0]     QLIM = CW'(QCNT_MAX);
    localparam logic [QCNT_W-1:0] QTOP = QCNT_W'(QCNT_MAX);

    logic [CW-1:0]     count_q;
    logic [QCNT_W-1:0] qcnt_q;

    assign left_o  = count_q - 1'b1;
    assign count_o = count_q;
    assign qcnt_o  = qcnt_q;
    assign empty_o = (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
            qcnt_q  <= '0;
        end else if (load) begin
            count_q <= FULL;
            qcnt_q  <= QTOP;
        end else if (consume) begin
            count_q <= left_o;
            if (left_o < QLIM)
                qcnt_q <= QCNT_W'(left_o);
        end
    end

endmodule

// File: rtl/rng_word_seq.sv
module rng_word_seq
    import rng_seq_pkg::*;
#(
    parameter logic [15:0]       HW_VERSION    = 16'h0200,
    parameter logic [DATA_W-1:0] SEED          = 32'h1234_5678,
    parameter int                BUDGET_LOG2   = 48,
    parameter int                WORDS_PER_GEN = 8,
    parameter int                QCNT_MAX      = 4,
    parameter int                REFILL_AT     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              sw_err,
    output logic              done
);

    localparam int CW = $clog2(WORDS_PER_GEN + 1);
    localparam logic [CW-1:0] REFILL_LIM = CW'(REFILL_AT);

    bus_req_t          bus;
    logic [DATA_W-1:0] ctrl_q, aux2_q, aux3_q, aux4_q, ctrl_wval;
    logic              reset_q, restore, ctrl_wr;
    logic [DATA_W-1:0] word;
    logic [CW-1:0]     avail_cnt, avail_left;
    logic [QCNT_W-1:0] qcnt;
    logic              empty;
    ctrl_act_e         act;
    logic              in_rst, rd, rd_word, word_ok, auto_mode, refill;
    logic              do_soft, do_gen, do_reseed;
    logic              done_q;
    logic [DATA_W-1:0] status_w, rd_mux;

    assign bus = '{req: req, we: we, addr: addr, wdata: wdata};

    rng_ctl_regs #(
        .HW_VERSION(HW_VERSION)
    ) i_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .ctrl_q   (ctrl_q),
        .aux2_q   (aux2_q),
        .aux3_q   (aux3_q),
        .aux4_q   (aux4_q),
        .reset_q  (reset_q),
        .restore  (restore),
        .ctrl_wr  (ctrl_wr),
        .ctrl_wval(ctrl_wval)
    );

    // action decode and word-read qualification
    assign in_rst    = reset_q | ctrl_q[CB_SOFT_RST];
    assign act       = ctrl_wr ? ctrl_action(ctrl_wval, reset_q) : ACT_IDLE;
    assign rd        = req & ~we;
    assign rd_word   = rd & (addr == OFS_WORD);
    assign word_ok   = rd_word & ~in_rst & ~empty;
    assign auto_mode = ctrl_q[CB_START] & ~ctrl_q[CB_SINGLE];
    assign refill    = word_ok & auto_mode & (avail_left <= REFILL_LIM);
    assign do_soft   = (act == ACT_SOFT);
    assign do_reseed = (act == ACT_RESEED);
    assign do_gen    = (act == ACT_GEN) | refill;

    rng_word_src #(
        .SEED       (SEED),
        .BUDGET_LOG2(BUDGET_LOG2)
    ) i_src (
        .clk    (clk),
        .rst    (rst),
        .restore(restore),
        .reseed (do_reseed),
        .gen    (do_gen),
        .advance(word_ok),
        .word_o (word)
    );

    rng_avail_ctr #(
        .WORDS_PER_GEN(WORDS_PER_GEN),
        .QCNT_MAX     (QCNT_MAX)
    ) i_ctr (
        .clk    (clk),
        .rst    (rst),
        .clear  (do_soft | restore),
        .load   (do_gen),
        .consume(word_ok),
        .count_o(avail_cnt),
        .left_o (avail_left),
        .qcnt_o (qcnt),
        .empty_o(empty)
    );

    always_ff @(posedge clk) begin
        if (rst || restore || do_soft)
            done_q <= 1'b0;
        else if (act == ACT_GEN || act == ACT_RESEED)
            done_q <= 1'b1;
    end

    assign done = done_q;

    always_comb begin
        status_w                   = '0;
        status_w[SB_QLO +: QCNT_W] = qcnt;
        status_w[SB_DONE]          = done_q;
    end

    always_comb begin
        case (addr)
            OFS_STATUS: rd_mux = status_w;
            OFS_CTRL:   rd_mux = ctrl_q;
            OFS_AUX2:   rd_mux = aux2_q;
            OFS_AUX3:   rd_mux = aux3_q;
            OFS_AUX4:   rd_mux = aux4_q;
            OFS_WORD:   rd_mux = word_ok ? word : BAD_WORD;
            OFS_RESET:  rd_mux = {{(DATA_W-1){1'b0}}, reset_q};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            sw_err <= 1'b0;
        end else begin
            rvalid <= rd;
            sw_err <= rd_word & ~word_ok;
            if (rd)
                rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/rng_word_seq_chk.sv
module rng_word_seq_chk
    import rng_seq_pkg::*;
#(
    parameter int WORDS_PER_GEN = 8,
    parameter int QCNT_MAX      = 4,
    localparam int CW           = $clog2(WORDS_PER_GEN + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        wbits,   // {gen, start, soft} write bits
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              sw_err,
    input logic              done,
    input logic              reset_q,
    input logic [CW-1:0]     count,
    input logic [QCNT_W-1:0] qcnt
);

    localparam logic [CW-1:0]     FULL = CW'(WORDS_PER_GEN);
    localparam logic [QCNT_W-1:0] QTOP = QCNT_W'(QCNT_MAX);

    logic wr_ctrl, wr_reset;
    assign wr_ctrl  = req & we & (addr == OFS_CTRL) & ~reset_q;
    assign wr_reset = req & we & (addr == OFS_RESET);

    assert_bad_in_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr == OFS_WORD && reset_q) |=> (rvalid && sw_err && rdata == BAD_WORD));

    assert_refused_value_R5: assert property (@(posedge clk) disable iff (rst)
        sw_err |-> (rvalid && rdata == BAD_WORD));

    assert_qcnt_cap_R4: assert property (@(posedge clk) disable iff (rst)
        qcnt <= QTOP);

    assert_count_cap_R2: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);

    assert_gen_fill_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wbits[0] && wbits[1] && wbits[2]) |=> (done && count == FULL && qcnt == QTOP));

    assert_soft_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wbits[0]) |=> (!done && count == '0 && qcnt == '0));

    assert_restore_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_reset && wbits[0] && !reset_q) |=> (reset_q && !done && count == '0));

    assert_read_latency_R13: assert property (@(posedge clk) disable iff (rst)
        (req && !we) |=> rvalid);

endmodule

bind rng_word_seq rng_word_seq_chk #(
    .WORDS_PER_GEN(WORDS_PER_GEN),
    .QCNT_MAX     (QCNT_MAX)
) i_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .we     (we),
    .addr   (addr),
    .wbits  ({wdata[7], wdata[5], wdata[0]}),
    .rdata  (rdata),
    .rvalid (rvalid),
    .sw_err (sw_err),
    .done   (done),
    .reset_q(reset_q),
    .count  (avail_cnt),
    .qcnt   (qcnt)
);

// File: tb/test_rng_word_seq.sv
module test_rng_word_seq;

    localparam logic [31:0] B_SEED = 32'h1234_5678;
    localparam logic [7:0]  A_STAT = 8'h04, A_CTRL = 8'h08, A_AUX2 = 8'h0C,
                            A_AUX3 = 8'h10, A_AUX4 = 8'h14, A_WORD = 8'hC0,
                            A_RST  = 8'hD0;
    localparam logic [31:0] BAD = 32'h0000_0BAD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
    logic [7:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_rvalid, b_rvalid, a_err, b_err, a_done, b_done;

    rng_word_seq #(.HW_VERSION(16'h0200), .SEED(B_SEED), .BUDGET_LOG2(2)) i_rng_word_seq (
        .clk(clk), .rst(rst), .req(a_req), .we(a_we), .addr(a_addr), .wdata(a_wdata),
        .rdata(a_rdata), .rvalid(a_rvalid), .sw_err(a_err), .done(a_done));

    rng_word_seq #(.HW_VERSION(16'h0100), .SEED(B_SEED)) i_rng_word_seq_legacy (
        .clk(clk), .rst(rst), .req(b_req), .we(b_we), .addr(b_addr), .wdata(b_wdata),
        .rdata(b_rdata), .rvalid(b_rvalid), .sw_err(b_err), .done(b_done));

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit          q_sel[$];
    logic [31:0] q_data[$];
    bit          q_err[$];
    string       q_tag[$];

    logic [31:0] w [0:16];

    function automatic logic [31:0] next_w(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one access, expected read results go to the scoreboard
    task automatic wr(input bit sel, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (sel) begin b_req = 1; b_we = 1; b_addr = a; b_wdata = d; end
        else     begin a_req = 1; a_we = 1; a_addr = a; a_wdata = d; end
        @(negedge clk);
        a_req = 0; b_req = 0;
    endtask

    task automatic rd(input bit sel, input logic [7:0] a, input logic [31:0] exp,
                      input bit err, input string tag);
        @(negedge clk);
        q_sel.push_back(sel); q_data.push_back(exp); q_err.push_back(err); q_tag.push_back(tag);
        if (sel) begin b_req = 1; b_we = 0; b_addr = a; end
        else     begin a_req = 1; a_we = 0; a_addr = a; end
        @(negedge clk);
        a_req = 0; b_req = 0;
    endtask

    task automatic take(input bit sel, input logic [31:0] d, input bit e);
        bit          s;
        logic [31:0] x;
        bit          xe;
        string       t;
        checks++;
        if (q_sel.size() == 0) begin
            fails++;
            $display("FAIL unexpected response actual=%h expected=none", d);
            return;
        end
        s = q_sel.pop_front(); x = q_data.pop_front(); xe = q_err.pop_front(); t = q_tag.pop_front();
        if (s != sel || d !== x || e !== xe) begin
            fails++;
            $display("FAIL %s actual=%h/err%0d/dut%0d expected=%h/err%0d/dut%0d",
                     t, d, e, sel, x, xe, s);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (a_rvalid) take(1'b0, a_rdata, a_err);
            if (b_rvalid) take(1'b1, b_rdata, b_err);
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        w[0] = B_SEED;
        for (int k = 1; k <= 16; k++) w[k] = next_w(w[k-1]);

        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 done after reset", {31'b0, a_done}, 32'd0);
        rd(0, A_RST,  32'd1, 0, "R1 reset reg");
        rd(0, A_STAT, 32'd0, 0, "R1 status");
        rd(0, A_AUX2, 32'h210C, 0, "R1 aux2");
        rd(0, A_AUX3, 32'h26F09, 0, "R1 aux3");
        rd(0, A_WORD, BAD, 1, "R7 word read in reset");

        // R7 control write in reset is stored, no action
        wr(0, A_CTRL, 32'h0000_00A0);
        rd(0, A_CTRL, 32'h0000_00A0, 0, "R7 ctrl stored in reset");
        rd(0, A_STAT, 32'd0, 0, "R7 no generate in reset");
        check("R7 done stays low", {31'b0, a_done}, 32'd0);

        // leave reset; single-generation generate
        wr(0, A_RST, 32'd0);
        wr(0, A_CTRL, 32'd0);
        wr(0, A_CTRL, 32'h0000_02A0);
        check("R2 done after generate", {31'b0, a_done}, 32'd1);
        rd(0, A_STAT, 32'h0000_0801, 0, "R2 qcnt 4 and done");
        for (int k = 1; k <= 4; k++) rd(0, A_WORD, w[k], 0, "R4 word");
        rd(0, A_STAT, 32'h0000_0801, 0, "R4 qcnt saturated at count 4");
        rd(0, A_WORD, w[5], 0, "R4 word 5");
        rd(0, A_STAT, 32'h0000_0601, 0, "R6 single mode no refill, qcnt 3");
        for (int k = 6; k <= 8; k++) rd(0, A_WORD, w[k], 0, "R4 word");
        rd(0, A_STAT, 32'h0000_0001, 0, "R4 qcnt 0");
        rd(0, A_WORD, BAD, 1, "R5 empty read");
        rd(0, A_STAT, 32'h0000_0001, 0, "R5 count unchanged");

        // R3 reseed restarts sequence, count unchanged
        wr(0, A_CTRL, 32'h0000_0220);
        rd(0, A_WORD, BAD, 1, "R3 reseed leaves count empty");
        wr(0, A_CTRL, 32'h0000_02A0);
        rd(0, A_WORD, w[1], 0, "R3 sequence from seed");

        // R12 budget exhaustion (budget 4)
        wr(0, A_CTRL, 32'h0000_02A0);
        rd(0, A_WORD, w[2], 0, "R12 budget 2");
        wr(0, A_CTRL, 32'h0000_02A0);
        rd(0, A_WORD, w[3], 0, "R12 budget 1");
        wr(0, A_CTRL, 32'h0000_02A0);
        rd(0, A_WORD, w[4], 0, "R12 budget 0");
        wr(0, A_CTRL, 32'h0000_02A0);
        rd(0, A_WORD, w[1], 0, "R12 forced reseed");

        // R8 soft reset
        rd(0, A_STAT, 32'h0000_0801, 0, "R8 status before soft reset");
        wr(0, A_CTRL, 32'h0000_0001);
        check("R8 done cleared", {31'b0, a_done}, 32'd0);
        rd(0, A_STAT, 32'd0, 0, "R8 status cleared");
        wr(0, A_CTRL, 32'd0);
        rd(0, A_WORD, BAD, 1, "R8 words discarded");

        // R6 automatic refill, R12 forced reseed on refill
        wr(0, A_CTRL, 32'h0000_00A0);
        for (int k = 2; k <= 6; k++) rd(0, A_WORD, w[k], 0, "R6 auto word");
        rd(0, A_STAT, 32'h0000_0801, 0, "R6 refilled to 4");
        for (int k = 7; k <= 16; k++) rd(0, A_WORD, w[k], 0, "R6 auto word");
        rd(0, A_WORD, w[1], 0, "R12 refill reseeds when budget out");

        // R11 current-version masking
        wr(0, A_CTRL, 32'h0000_0612);
        rd(0, A_CTRL, 32'h0000_0600, 0, "R11 bits 1 and 4 forced 0");
        wr(0, A_AUX2, 32'h0000_ABCD);
        rd(0, A_AUX2, 32'h0000_ABCD, 0, "R11 aux2 writable");
        wr(0, A_AUX3, 32'h0000_0055);
        rd(0, A_AUX3, 32'h0000_0055, 0, "R11 aux3 writable");
        wr(0, A_AUX4, 32'h0000_0001);
        rd(0, A_AUX4, 32'h0000_0001, 0, "R11 aux4 writable");

        // R9 restore via reset register
        wr(0, A_RST, 32'd1);
        rd(0, A_CTRL, 32'd0, 0, "R9 ctrl restored");
        rd(0, A_AUX2, 32'h210C, 0, "R9 aux2 restored");
        rd(0, A_AUX3, 32'h26F09, 0, "R9 aux3 restored");
        rd(0, A_AUX4, 32'd0, 0, "R9 aux4 restored");
        rd(0, A_RST, 32'd1, 0, "R9 reset reg set");
        rd(0, A_STAT, 32'd0, 0, "R9 status restored");
        rd(0, A_WORD, BAD, 1, "R9 word read in reset");
        wr(0, A_RST, 32'd0);
        wr(0, A_CTRL, 32'h0000_02A0);
        rd(0, A_WORD, w[1], 0, "R9 generator restored");

        // R10 legacy version
        wr(1, A_RST, 32'd0);
        wr(1, A_CTRL, 32'h0000_0612);
        rd(1, A_CTRL, 32'h0000_0012, 0, "R10 bits 9 and 10 forced 0");
        wr(1, A_AUX2, 32'h0000_ABCD);
        rd(1, A_AUX2, 32'h210C, 0, "R10 aux2 write ignored");
        wr(1, A_AUX4, 32'h0000_0001);
        rd(1, A_AUX4, 32'd0, 0, "R10 aux4 write ignored");
        wr(1, A_CTRL, 32'h0000_02A0);
        rd(1, A_CTRL, 32'h0000_00A0, 0, "R10 single bit dropped");
        for (int k = 1; k <= 5; k++) rd(1, A_WORD, w[k], 0, "R10 legacy word");
        rd(1, A_STAT, 32'h0000_0801, 0, "R10 auto refill since single dropped");

        repeat (3) @(negedge clk);
        check("R13 all responses arrived", q_sel.size(), 32'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule